// File: doc/BRIEF.md
# Margin-verified EPROM programming sequencer

This block is a host-side controller. It programs one 16-bit EPROM word using an adaptive pulse algorithm. The controller does not drive the device pins. It issues a stream of commands to a device-port driver: select a supply level, run a blank check, apply a program pulse, or verify the word. The driver answers each command with a pass or fail flag. The sequencer counts pulses and, once the word reads back correctly, adds a margin of extra pulses. It then confirms the word at both supply extremes and reports a status code.

A second mode programs the configuration area. The sequencer walks the configuration offsets in ascending order and skips the reserved ones. The data written there is immaterial, because any write programs the bit. Each configuration location uses a higher pulse limit and receives no margin pulses. The pulse width is set by the parameter `PULSE_CYC` in clock cycles. It should correspond to between 10 µs and 1000 µs; the default is 100 µs at 125 MHz.

Top module: `eprom_prog_seq`

## Requirements
- R1: On start the sequencer clears the pulse count, selects the minimum level and issues a blank check. If the blank check fails, the run ends with status 1 and no pulse is issued.
- R2: Programming pulses are issued only while the programming level is selected. Each pulse keeps `cmd_valid` high with op 3 for exactly `PULSE_CYC` cycles. During the search phase, every pulse is followed by one verify.
- R3: In normal mode the pulse count is compared after each failed verify. The location is abandoned with status 2 as soon as a failed verify follows pulse number 26, that is, when the count exceeds 25. A location that first passes on pulse 26 still succeeds.
- R4: In normal mode, the first passing verify is followed by extra pulses. Their number is three times the number of pulses applied up to that point.
- R5: After the margin pulses, or right after the first pass in configuration mode, the word is verified at the maximum level and then at the minimum level. A failure at either level ends the run with status 3.
- R6: In configuration mode, a failed verify after the 100th pulse ends the run with status 2, so a location may pass on its 100th pulse. No margin pulses are applied.
- R7: In configuration mode the sequencer programs CFG_BASE plus offsets 0, 1, 2, 3, 4, 6 and 15, in that order. Reserved offsets produce no command. The data presented is 0000h.
- R8: `busy` stays high from the start until the cycle of `done`, then falls. `done` lasts one cycle, and `status` is 0 for success.
- R9: Command encoding on `cmd_op` is: 1 set level, 2 blank check, 3 pulse, 4 verify. Level encoding on `cmd_level` is: 0 minimum, 1 programming, 2 maximum. Every op other than a pulse waits for a one-cycle `cmd_ack`, and `cmd_ok` is read with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run; accepted when idle |
| cfg_mode | input | 1 | 1 selects the configuration walk |
| addr_in | input | 16 | Word address in normal mode |
| data_in | input | 16 | Word value in normal mode |
| cmd_valid | output | 1 | Command present to the driver |
| cmd_op | output | 3 | Command code |
| cmd_level | output | 2 | Supply level for a set-level command |
| cmd_addr | output | 16 | Address of the word being worked on |
| cmd_data | output | 16 | Data to program and to compare |
| cmd_ack | input | 1 | Driver completed the current command |
| cmd_ok | input | 1 | Result of a blank check or verify |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 2 | Result code, valid with done |

## Verification
The hardest cases to reach are the pulse-limit boundaries. They need a device model that stays unprogrammed for an exact number of pulses. The bench driver therefore keeps a per-offset count of pulses still required. It runs locations that pass on pulse 26 and never pass in normal mode, and a configuration location that passes on pulse 100 or needs 101. Failures at a single supply extreme are injected by making the model fail verifies only at that level. The last two verify levels are logged, which shows the maximum-then-minimum order.

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq #(
  parameter int PULSE_CYC  = 12500,
  parameter int NORM_LIMIT = 25,
  parameter int CFG_LIMIT  = 100,
  parameter int MARGIN_MUL = 3,
  parameter int CNT_W      = 8,
  parameter logic [15:0] CFG_BASE = 16'hFE00,
  parameter logic [15:0] CFG_SKIP = 16'h7FA0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        cfg_mode,
  input  logic [15:0] addr_in,
  input  logic [15:0] data_in,
  output logic        cmd_valid,
  output logic [2:0]  cmd_op,
  output logic [1:0]  cmd_level,
  output logic [15:0] cmd_addr,
  output logic [15:0] cmd_data,
  input  logic        cmd_ack,
  input  logic        cmd_ok,
  output logic        busy,
  output logic        done,
  output logic [1:0]  status
);
  localparam int TMR_W = $clog2(PULSE_CYC + 1);
  localparam int MRG_W = CNT_W + $clog2(MARGIN_MUL + 1);
  localparam logic [2:0] OP_LVL = 3'd1, OP_BLANK = 3'd2, OP_PULSE = 3'd3, OP_VER = 3'd4;
  localparam logic [1:0] LV_MIN = 2'd0, LV_PROG = 2'd1, LV_MAX = 2'd2;
  localparam logic [1:0] ST_OK = 2'd0, ST_BLANK_BAD = 2'd1, ST_UNABLE = 2'd2, ST_VLIM = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_SETMIN0, S_BLANK, S_SETPROG, S_PULSE, S_VERP, S_MARGIN,
    S_SETMAX, S_VERMAX, S_SETMIN1, S_VERMIN, S_NEXT, S_DONE
  } state_t;

  state_t            state;
  logic              cfg_r;
  logic [15:0]       addr_r, data_r;
  logic [3:0]        off;
  logic [CNT_W-1:0]  cnt;
  logic [MRG_W-1:0]  mrg;
  logic [TMR_W-1:0]  tmr;
  logic [1:0]        status_r, lvl_r;

  wire pulse_st  = (state == S_PULSE) || (state == S_MARGIN);
  wire pulse_end = pulse_st && (tmr == TMR_W'(PULSE_CYC));
  wire limit_hit = cfg_r ? (cnt >= CNT_W'(CFG_LIMIT)) : (cnt > CNT_W'(NORM_LIMIT));

  always_comb begin
    case (state)
      S_SETMIN0, S_SETPROG, S_SETMAX, S_SETMIN1: cmd_op = OP_LVL;
      S_BLANK:                                   cmd_op = OP_BLANK;
      S_PULSE, S_MARGIN:                         cmd_op = OP_PULSE;
      S_VERP, S_VERMAX, S_VERMIN:                cmd_op = OP_VER;
      default:                                   cmd_op = 3'd0;
    endcase
  end

  assign cmd_level = (state == S_SETPROG) ? LV_PROG : (state == S_SETMAX) ? LV_MAX : LV_MIN;
  assign cmd_valid = pulse_st ? !pulse_end : (cmd_op != 3'd0);
  assign cmd_addr  = cfg_r ? (CFG_BASE + {12'd0, off}) : addr_r;
  assign cmd_data  = cfg_r ? 16'h0000 : data_r;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
  assign status    = status_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cfg_r <= 1'b0; addr_r <= '0; data_r <= '0; off <= '0;
      cnt <= '0; mrg <= '0; tmr <= '0; status_r <= ST_OK; lvl_r <= LV_MIN;
    end else begin
      if (cmd_valid && cmd_op == OP_LVL && cmd_ack) lvl_r <= cmd_level;
      case (state)
        S_IDLE: if (start) begin
          cfg_r <= cfg_mode; addr_r <= addr_in; data_r <= data_in; off <= '0;
          state <= S_SETMIN0;
        end
        S_SETMIN0: begin
          cnt <= '0;
          if (cmd_ack) state <= S_BLANK;
        end
        S_BLANK: if (cmd_ack) begin
          if (cmd_ok) state <= S_SETPROG;
          else begin status_r <= ST_BLANK_BAD; state <= S_DONE; end
        end
        S_SETPROG: if (cmd_ack) begin tmr <= '0; state <= S_PULSE; end
        S_PULSE: if (pulse_end) begin
          tmr <= '0; cnt <= cnt + 1'b1; state <= S_VERP;
        end else tmr <= tmr + 1'b1;
        S_VERP: if (cmd_ack) begin
          if (cmd_ok) begin
            if (cfg_r) state <= S_SETMAX;
            else begin
              mrg <= MRG_W'(cnt) * MRG_W'(MARGIN_MUL); tmr <= '0; state <= S_MARGIN;
            end
          end else if (limit_hit) begin
            status_r <= ST_UNABLE; state <= S_DONE;
          end else state <= S_PULSE;
        end
        S_MARGIN: if (pulse_end) begin
          tmr <= '0; mrg <= mrg - 1'b1;
          if (mrg == MRG_W'(1)) state <= S_SETMAX;
        end else tmr <= tmr + 1'b1;
        S_SETMAX:  if (cmd_ack) state <= S_VERMAX;
        S_VERMAX:  if (cmd_ack) begin
          if (cmd_ok) state <= S_SETMIN1;
          else begin status_r <= ST_VLIM; state <= S_DONE; end
        end
        S_SETMIN1: if (cmd_ack) state <= S_VERMIN;
        S_VERMIN:  if (cmd_ack) begin
          if (!cmd_ok) begin status_r <= ST_VLIM; state <= S_DONE; end
          else if (cfg_r) state <= S_NEXT;
          else begin status_r <= ST_OK; state <= S_DONE; end
        end
        S_NEXT: if (off == 4'hF) begin
          status_r <= ST_OK; state <= S_DONE;
        end else begin
          off <= off + 1'b1;
          if (!CFG_SKIP[off + 1'b1]) state <= S_SETMIN0;
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_PULSE_AT_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PULSE) |-> (lvl_r == LV_PROG)); // R2
  AST_NORM_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg_r) |-> (cnt <= CNT_W'(NORM_LIMIT + 1))); // R3
  AST_CFG_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_r) |-> (cnt <= CNT_W'(CFG_LIMIT))); // R6
  AST_CFG_NO_MARGIN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_r |-> (state != S_MARGIN)); // R6
  AST_CFG_ADDR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_r && cmd_valid) |-> !CFG_SKIP[cmd_addr[3:0]]); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R8
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cfg_r && $past(cmd_valid)) |-> $stable(cmd_addr)); // R9
endmodule

// File: tb/eprom_prog_seq_test.sv
module eprom_prog_seq_test;
  localparam int PC = 20;
  logic clk = 0, rst_n = 0, start = 0, cfg_mode = 0;
  logic [15:0] addr_in = 0, data_in = 0;
  logic cmd_valid, cmd_ack = 0, cmd_ok = 0, busy, done;
  logic [2:0] cmd_op;
  logic [1:0] cmd_level, status;
  logic [15:0] cmd_addr, cmd_data;

  eprom_prog_seq #(.PULSE_CYC(PC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
    .addr_in(addr_in), .data_in(data_in), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_level(cmd_level), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_ack(cmd_ack), .cmd_ok(cmd_ok), .busy(busy), .done(done), .status(status));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int need[16], got[16];
  logic [15:0] blog[16];
  bit blank_bad, fmax, fmin;
  int lvl, pulses, wbad, w, blanks, pver, vlast, vprev, dly, pidx, busy_drop;
  logic [15:0] pdata;
  logic [1:0] st;

  task automatic chk(input bit c, input string tag, input int act, input int exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog actual %0d expected 0", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cmd_valid && cmd_op == 3'd3) begin
      w++; pdata = cmd_data; pidx = cmd_addr[3:0];
    end else if (w != 0) begin
      pulses++; if (w != PC) wbad++; got[pidx]++; w = 0;
    end
    if (cmd_ack) cmd_ack = 0;
    else if (cmd_valid && cmd_op != 3'd3) begin
      if (dly == 2) begin
        dly = 0; cmd_ack = 1;
        case (cmd_op)
          3'd1: begin lvl = cmd_level; cmd_ok = 1; end
          3'd2: begin if (blanks < 16) blog[blanks] = cmd_addr; blanks++; cmd_ok = !blank_bad; end
          3'd4: begin
            cmd_ok = (got[cmd_addr[3:0]] >= need[cmd_addr[3:0]]) &&
                     !(lvl == 2 && fmax) && !(lvl == 0 && fmin);
            if (lvl == 1) pver++;
            vprev = vlast; vlast = lvl;
          end
          default: cmd_ok = 0;
        endcase
      end else dly++;
    end
  end

  task automatic clear_model();
    for (int i = 0; i < 16; i++) begin need[i] = 1; got[i] = 0; blog[i] = 0; end
    blank_bad = 0; fmax = 0; fmin = 0; lvl = -1; pulses = 0; wbad = 0;
    blanks = 0; pver = 0; vlast = -1; vprev = -1; busy_drop = 0;
  endtask

  task automatic run(input bit cfg, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); cfg_mode = cfg; addr_in = a; data_in = d; start = 1;
    @(negedge clk); start = 0;
    while (!done) begin
      if (!busy) busy_drop++;
      @(negedge clk);
    end
    st = status;
    @(negedge clk);
    chk(!busy, "R8 busy falls after done", busy, 0);
  endtask

  task automatic t_reset();
    chk(!cmd_valid && !busy && !done, "R8 reset idle", {cmd_valid, busy, done}, 0);
  endtask

  task automatic t_blank_fail();
    clear_model(); blank_bad = 1;
    run(0, 16'h0123, 16'hA5A5);
    chk(st == 1, "R1 blank fail status", st, 1);
    chk(pulses == 0, "R1 no pulses after blank fail", pulses, 0);
    chk(blanks == 1 && lvl == 0, "R1 blank check at min level", lvl, 0);
  endtask

  task automatic t_norm(input int n);
    clear_model(); need[3] = n;
    run(0, 16'h0123, 16'h5A3C);
    chk(st == 0, "R8 normal success status", st, 0);
    chk(busy_drop == 0, "R8 busy held", busy_drop, 0);
    chk(pulses == 4 * n, "R4 search plus margin pulses", pulses, 4 * n);
    chk(pver == n, "R2 one verify per search pulse", pver, n);
    chk(wbad == 0, "R2 pulse width", wbad, 0);
    chk(vprev == 2 && vlast == 0, "R5 verify max then min", vprev * 10 + vlast, 20);
    chk(pdata == 16'h5A3C, "R9 data presented", pdata, 16'h5A3C);
  endtask

  task automatic t_norm_unable();
    clear_model(); need[3] = 27;
    run(0, 16'h0123, 16'h1111);
    chk(st == 2, "R3 unable status", st, 2);
    chk(pulses == 26, "R3 pulses before giving up", pulses, 26);
  endtask

  task automatic t_vlim(input bit at_max);
    clear_model(); need[3] = 2; fmax = at_max; fmin = !at_max;
    run(0, 16'h0123, 16'h2222);
    chk(st == 3, "R5 supply limit fail status", st, 3);
    chk(vlast == (at_max ? 2 : 0), "R5 failing level", vlast, at_max ? 2 : 0);
    chk(pulses == 8, "R4 margin before limit verify", pulses, 8);
  endtask

  task automatic t_cfg_walk();
    int exp_off[7] = '{0, 1, 2, 3, 4, 6, 15};
    clear_model();
    run(1, 16'h0000, 16'hFFFF);
    chk(st == 0, "R7 config walk status", st, 0);
    chk(blanks == 7, "R7 locations visited", blanks, 7);
    for (int i = 0; i < 7; i++)
      chk(blog[i] == 16'hFE00 + 16'(exp_off[i]), "R7 walk order", blog[i], 16'hFE00 + exp_off[i]);
    chk(pulses == 7, "R6 no margin pulses in config", pulses, 7);
    chk(pdata == 16'h0000, "R7 config data", pdata, 0);
  endtask

  task automatic t_cfg_limit(input int n);
    clear_model(); need[0] = n;
    run(1, 16'h0000, 16'h0000);
    if (n <= 100) begin
      chk(st == 0, "R6 config passes at limit", st, 0);
      chk(pulses == n + 6, "R6 config pulse total", pulses, n + 6);
    end else begin
      chk(st == 2, "R6 config unable status", st, 2);
      chk(pulses == 100, "R6 config pulses before giving up", pulses, 100);
      chk(blanks == 1, "R6 walk stops on error", blanks, 1);
    end
  endtask

  initial begin
    clear_model(); dly = 0; w = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_blank_fail();
    t_norm(1);
    t_norm(5);
    t_norm(26);
    t_norm_unable();
    t_vlim(1);
    t_vlim(0);
    t_cfg_walk();
    t_cfg_limit(100);
    t_cfg_limit(101);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule